// File: doc/BRIEF.md
# SMBus Byte-Data Master

This block is a register-mapped two-wire bus master for configuring an image sensor with SMBus byte-data transfers. Software first programs a configuration word with the enable, the 7-bit target address, the bus clock divider and two option bits. It then writes a command word that holds the sensor register address, the data byte and a read flag. That one write runs the whole transfer on the bus: START, the target address with the write bit, the register address, and then either the data byte or a repeated START, the address with the read bit and one received byte. A STOP closes the transfer.

Progress is reported in the command word. A pending-write flag is set while a write is running. A read-valid flag is set when a received byte is ready in the low data bits. An error flag is set when the target fails to acknowledge. A completion status bit is raised at the end of every transfer and is cleared by writing one to it. A separate enable register gates it onto the interrupt pin. SCL is driven push-pull. SDA is open-drain: the master can only pull it low or release it.

Top module: `smb_byte_master`

Register offsets on `bus_addr`: 0 = configuration, 1 = command/status, 2 = completion status (bit 0, write one to clear), 3 = interrupt enable (bit 0).

## Requirements
- R1: After reset, the configuration word reads back with every divider bit (18:10) set and all other bits 0. The command word and completion status read 0. SCL is high and SDA is released.
- R2: While a transfer runs, each SCL period lasts 2×(divider+1) clock cycles. While idle, SCL is high and SDA is released.
- R3: A command with bit 24 clear performs START, address+W, register address (bits 23:16), data byte (bits 7:0), STOP. Bit 25 reads 1 from the command write until completion and 0 afterwards.
- R4: A command with bit 24 set performs START, address+W, register address, repeated START, address+R, one received byte answered with NACK, STOP. On success bit 26 is set, bits 7:0 hold the byte and bits 15:8 are 0.
- R5: A missing acknowledge on any transmitted byte sets bit 27, ends the transfer with STOP, and leaves bit 26 clear.
- R6: With configuration bit 22 set, missing acknowledges are ignored and the transfer completes without error.
- R7: A command write that arrives while a transfer is running has no effect on the bus or on the command word.
- R8: A command write while configuration bit 0 (enable) is clear starts nothing: SCL stays high and bit 25 stays 0.
- R9: An accepted command clears bits 26 and 27. It sets bit 25 only for a write command.
- R10: Every completion sets completion status bit 0. Writing 1 to it clears it. The interrupt pin equals that status ANDed with enable register bit 0.
- R11: SDA changes while SCL is high only to form START or STOP. A write makes one START and one STOP; a read makes two STARTs and one STOP.
- R12: Configuration bits 1 (wide data) and 23 (compatibility timing) are stored and read back. Transfers stay byte-data regardless of their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| scl_o | output | 1 | Bus clock level |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sensed SDA line level |
| irq_o | output | 1 | Completion interrupt |

## Verification
The assertions check on every cycle that the idle bus is released, that SDA is steady during each SCL-high bit phase, and that completion raises the status bit and clears the pending-write flag. They also check that read-valid and error never coexist, that commands arriving while busy or disabled change nothing, and that no transfer starts from them. Only the bench scenarios, which run against a behavioural sensor model, can show correct bus content. That covers register writes landing in the sensor, returned bytes matching, the SCL period for each divider, START/STOP counts, NACK and masked-NACK outcomes, and the interrupt gating.

// File: rtl/smb_pkg.sv
package smb_pkg;
    localparam int ADDR_W      = 2;
    localparam int WORD_W      = 32;
    localparam int CFG_EN      = 0;
    localparam int CFG_WIDE    = 1;
    localparam int CFG_SID_LO  = 3;
    localparam int CFG_SID_HI  = 9;
    localparam int CFG_DIV_LO  = 10;
    localparam int CFG_DIV_HI  = 18;
    localparam int CFG_MASKACK = 22;
    localparam int CFG_COMPAT  = 23;
    localparam int CMD_RD      = 24;
    localparam int CMD_WPEND   = 25;
    localparam int CMD_RVAL    = 26;
    localparam int CMD_ERR     = 27;
    localparam int DIV_W       = CFG_DIV_HI - CFG_DIV_LO + 1;
    localparam int SID_W       = CFG_SID_HI - CFG_SID_LO + 1;

    localparam logic [ADDR_W-1:0] REG_CFG = 2'd0;
    localparam logic [ADDR_W-1:0] REG_CMD = 2'd1;
    localparam logic [ADDR_W-1:0] REG_IST = 2'd2;
    localparam logic [ADDR_W-1:0] REG_IEN = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_BITS  = 2'd2,
        ST_STOP  = 2'd3
    } bus_st_e;
endpackage

// File: rtl/smb_tick_gen.sv
module smb_tick_gen #(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == div);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/smb_seq.sv
module smb_seq
    import smb_pkg::*;
#(
    parameter int SID_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             go,
    input  logic             go_rd,
    input  logic [SID_W-1:0] go_sid,
    input  logic [7:0]       go_reg,
    input  logic [7:0]       go_data,
    input  logic             go_mask,
    input  logic             sda_in,
    output logic             busy,
    output logic             in_bits,
    output logic             scl_o,
    output logic             sda_low_o,
    output logic             done_o,
    output logic             err_o,
    output logic [7:0]       rx_o
);
    localparam logic [3:0] ACK_SLOT = 4'd8;

    typedef struct packed {
        bus_st_e          st;
        logic [1:0]       ph;
        logic [3:0]       bitn;
        logic [1:0]       seg;
        logic [7:0]       sh;
        logic [7:0]       rx;
        logic             err;
        logic             rd;
        logic             mask;
        logic [SID_W-1:0] sid;
        logic [7:0]       rg;
        logic [7:0]       dat;
        logic             scl;
        logic             sdl;
        logic             done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic rcv;

    // byte sent in each segment: 0 addr+W, 1 register, 2 data or addr+R
    function automatic logic [7:0] seg_byte(input seq_t s, input logic [1:0] sg);
        case (sg)
            2'd0:    seg_byte = {s.sid, 1'b0};
            2'd1:    seg_byte = s.rg;
            2'd2:    seg_byte = s.rd ? {s.sid, 1'b1} : s.dat;
            default: seg_byte = 8'h00;
        endcase
    endfunction

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        rcv        = seq_q.rd && (seq_q.seg == 2'd3);
        case (seq_q.st)
            ST_IDLE: if (go) begin
                seq_d.st   = ST_START;
                seq_d.ph   = 2'd0;
                seq_d.seg  = 2'd0;
                seq_d.err  = 1'b0;
                seq_d.rd   = go_rd;
                seq_d.mask = go_mask;
                seq_d.sid  = go_sid;
                seq_d.rg   = go_reg;
                seq_d.dat  = go_data;
                seq_d.scl  = 1'b0;
                seq_d.sdl  = 1'b0;
            end
            ST_START: if (tick) begin
                case (seq_q.ph)
                    2'd0: begin seq_d.ph = 2'd1; seq_d.scl = 1'b1; end
                    2'd1: begin seq_d.ph = 2'd2; seq_d.sdl = 1'b1; end
                    default: begin
                        seq_d.st   = ST_BITS;
                        seq_d.ph   = 2'd0;
                        seq_d.bitn = 4'd0;
                        seq_d.scl  = 1'b0;
                        seq_d.sh   = seg_byte(seq_q, seq_q.seg);
                        seq_d.sdl  = ~seq_d.sh[7];
                    end
                endcase
            end
            ST_BITS: if (tick) begin
                if (seq_q.ph == 2'd0) begin
                    seq_d.ph  = 2'd1;
                    seq_d.scl = 1'b1;
                end else begin
                    seq_d.ph  = 2'd0;
                    seq_d.scl = 1'b0;
                    if (seq_q.bitn == ACK_SLOT) begin
                        seq_d.bitn = 4'd0;
                        seq_d.sdl  = 1'b0;
                        if (!rcv && sda_in && !seq_q.mask) begin
                            seq_d.err = 1'b1;
                            seq_d.st  = ST_STOP;
                            seq_d.sdl = 1'b1;
                        end else if (rcv || (!seq_q.rd && seq_q.seg == 2'd2)) begin
                            seq_d.st  = ST_STOP;
                            seq_d.sdl = 1'b1;
                        end else if (seq_q.rd && seq_q.seg == 2'd1) begin
                            seq_d.st  = ST_START;
                            seq_d.seg = 2'd2;
                        end else begin
                            seq_d.seg = seq_q.seg + 2'd1;
                            seq_d.sh  = seg_byte(seq_q, seq_q.seg + 2'd1);
                            seq_d.sdl = (seq_q.rd && seq_q.seg == 2'd2) ? 1'b0 : ~seq_d.sh[7];
                        end
                    end else begin
                        seq_d.bitn = seq_q.bitn + 4'd1;
                        if (rcv) seq_d.rx = {seq_q.rx[6:0], sda_in};
                        seq_d.sh  = {seq_q.sh[6:0], 1'b0};
                        seq_d.sdl = (rcv || seq_q.bitn == 4'd7) ? 1'b0 : ~seq_d.sh[7];
                    end
                end
            end
            ST_STOP: if (tick) begin
                case (seq_q.ph)
                    2'd0: begin seq_d.ph = 2'd1; seq_d.scl = 1'b1; end
                    2'd1: begin seq_d.ph = 2'd2; seq_d.sdl = 1'b0; end
                    default: begin
                        seq_d.st   = ST_IDLE;
                        seq_d.ph   = 2'd0;
                        seq_d.done = 1'b1;
                    end
                endcase
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q     <= '0;
            seq_q.scl <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy      = (seq_q.st != ST_IDLE);
    assign in_bits   = (seq_q.st == ST_BITS);
    assign scl_o     = seq_q.scl;
    assign sda_low_o = seq_q.sdl;
    assign done_o    = seq_q.done;
    assign err_o     = seq_q.err;
    assign rx_o      = seq_q.rx;
endmodule

// File: rtl/smb_byte_master.sv
module smb_byte_master
    import smb_pkg::*;
#(
    parameter logic [DIV_W-1:0] DIV_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              scl_o,
    output logic              sda_low_o,
    input  logic              sda_in,
    output logic              irq_o
);
    typedef struct packed {
        logic             en;
        logic             wide;
        logic [SID_W-1:0] sid;
        logic [DIV_W-1:0] div;
        logic             mask;
        logic             compat;
        logic [15:0]      data;
        logic [7:0]       raddr;
        logic             rd;
        logic             wpend;
        logic             rval;
        logic             err;
        logic             irq;
        logic             irqen;
    } regs_t;

    regs_t      r_d, r_q;
    logic       go, tick, seq_busy, seq_bits, seq_done, seq_err;
    logic [7:0] seq_rx;

    smb_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (seq_busy),
        .div  (r_q.div),
        .tick (tick)
    );

    smb_seq #(.SID_W(SID_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .go       (go),
        .go_rd    (bus_wdata[CMD_RD]),
        .go_sid   (r_q.sid),
        .go_reg   (bus_wdata[23:16]),
        .go_data  (bus_wdata[7:0]),
        .go_mask  (r_q.mask),
        .sda_in   (sda_in),
        .busy     (seq_busy),
        .in_bits  (seq_bits),
        .scl_o    (scl_o),
        .sda_low_o(sda_low_o),
        .done_o   (seq_done),
        .err_o    (seq_err),
        .rx_o     (seq_rx)
    );

    always_comb begin
        r_d = r_q;
        go  = 1'b0;
        if (bus_wr) begin
            case (bus_addr)
                REG_CFG: begin
                    r_d.en     = bus_wdata[CFG_EN];
                    r_d.wide   = bus_wdata[CFG_WIDE];
                    r_d.sid    = bus_wdata[CFG_SID_HI:CFG_SID_LO];
                    r_d.div    = bus_wdata[CFG_DIV_HI:CFG_DIV_LO];
                    r_d.mask   = bus_wdata[CFG_MASKACK];
                    r_d.compat = bus_wdata[CFG_COMPAT];
                end
                REG_CMD: if (r_q.en && !seq_busy && !seq_done) begin
                    go        = 1'b1;
                    r_d.data  = bus_wdata[15:0];
                    r_d.raddr = bus_wdata[23:16];
                    r_d.rd    = bus_wdata[CMD_RD];
                    r_d.wpend = !bus_wdata[CMD_RD];
                    r_d.rval  = 1'b0;
                    r_d.err   = 1'b0;
                end
                REG_IST: if (bus_wdata[0]) r_d.irq = 1'b0;
                default: r_d.irqen = bus_wdata[0];
            endcase
        end
        if (seq_done) begin
            r_d.wpend = 1'b0;
            r_d.err   = seq_err;
            r_d.irq   = 1'b1;
            if (r_q.rd && !seq_err) begin
                r_d.rval = 1'b1;
                r_d.data = {8'h00, seq_rx};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.div <= DIV_RST;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CFG: begin
                bus_rdata[CFG_EN]                = r_q.en;
                bus_rdata[CFG_WIDE]              = r_q.wide;
                bus_rdata[CFG_SID_HI:CFG_SID_LO] = r_q.sid;
                bus_rdata[CFG_DIV_HI:CFG_DIV_LO] = r_q.div;
                bus_rdata[CFG_MASKACK]           = r_q.mask;
                bus_rdata[CFG_COMPAT]            = r_q.compat;
            end
            REG_CMD: begin
                bus_rdata[15:0]      = r_q.data;
                bus_rdata[23:16]     = r_q.raddr;
                bus_rdata[CMD_RD]    = r_q.rd;
                bus_rdata[CMD_WPEND] = r_q.wpend;
                bus_rdata[CMD_RVAL]  = r_q.rval;
                bus_rdata[CMD_ERR]   = r_q.err;
            end
            REG_IST: bus_rdata[0] = r_q.irq;
            default: bus_rdata[0] = r_q.irqen;
        endcase
    end

    assign irq_o = r_q.irq & r_q.irqen;
endmodule

// File: rtl/smb_byte_master_chk.sv
module smb_byte_master_chk
    import smb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              busy,
    input logic              in_bits,
    input logic              scl,
    input logic              sdl,
    input logic              done,
    input logic              irq_st,
    input logic              wpend,
    input logic              rval,
    input logic              err,
    input logic              en,
    input logic [7:0]        raddr,
    input logic              rd
);
    a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl && !sdl));

    a_r11_sda_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (in_bits && $past(in_bits) && scl && $past(scl)) |-> $stable(sdl));

    a_r10_done_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> irq_st);

    a_r3_done_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !wpend);

    a_r5_valid_excludes_error: assert property (@(posedge clk) disable iff (!rst_n)
        !(rval && err));

    a_r7_busy_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && bus_addr == REG_CMD) |=> ($stable(raddr) && $stable(rd)));

    a_r8_disabled_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !en && bus_wr && bus_addr == REG_CMD) |=> !busy);
endmodule

bind smb_byte_master smb_byte_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .busy    (seq_busy),
    .in_bits (seq_bits),
    .scl     (scl_o),
    .sdl     (sda_low_o),
    .done    (seq_done),
    .irq_st  (r_q.irq),
    .wpend   (r_q.wpend),
    .rval    (r_q.rval),
    .err     (r_q.err),
    .en      (r_q.en),
    .raddr   (r_q.raddr),
    .rd      (r_q.rd)
);

// File: tb/smb_byte_master_tb.sv
module smb_byte_master_tb;
    localparam logic [6:0] SADDR = 7'h21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        scl_o, sda_low_o, irq_o;
    logic        pull;
    logic        sda_line;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    assign sda_line = !(sda_low_o || pull);

    always #2 clk = ~clk;

    smb_byte_master u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .scl_o    (scl_o),
        .sda_low_o(sda_low_o),
        .sda_in   (sda_line),
        .irq_o    (irq_o)
    );

    function automatic logic [7:0] init_val(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    // ---------------- sensor model ----------------
    logic       scl_p = 1'b1, sda_p = 1'b1, act = 1'b0, rdm = 1'b0;
    logic [3:0] bc = '0;
    logic [1:0] bn = '0;
    logic [7:0] sh = '0, ptr = '0, txb = '0;
    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    int starts = 0, stops = 0;
    int rises = 0, t_r2 = 0, t_r3 = 0;

    initial begin
        pull = 1'b0;
        for (int i = 0; i < 256; i++) begin
            mem[i]     = init_val(i);
            exp_mem[i] = init_val(i);
        end
    end

    always @(posedge clk) begin
        cyc   <= cyc + 1;
        scl_p <= scl_o;
        sda_p <= sda_line;
        if (scl_o && !scl_p) begin
            rises <= rises + 1;
            if (rises == 1) t_r2 <= cyc;
            if (rises == 2) t_r3 <= cyc;
        end
        if (scl_o && scl_p && sda_p && !sda_line) begin
            starts <= starts + 1;
            act <= 1'b1; bc <= '0; bn <= '0; rdm <= 1'b0; pull <= 1'b0;
        end else if (scl_o && scl_p && !sda_p && sda_line) begin
            stops <= stops + 1;
            act <= 1'b0; pull <= 1'b0;
        end else if (act && scl_o && !scl_p) begin
            bc <= bc + 4'd1;
            if (bc < 4'd8 && !(rdm && bn != 2'd0)) sh <= {sh[6:0], sda_line};
        end else if (act && !scl_o && scl_p) begin
            if (bc == 4'd8) begin
                if (rdm && bn != 2'd0) pull <= 1'b0;
                else if (bn == 2'd0) begin
                    if (sh[7:1] == SADDR) begin pull <= 1'b1; rdm <= sh[0]; end
                    else begin act <= 1'b0; pull <= 1'b0; end
                end else if (bn == 2'd1) begin ptr <= sh; pull <= 1'b1; end
                else begin mem[ptr] <= sh; pull <= 1'b1; end
            end else if (bc == 4'd9) begin
                bc <= '0;
                bn <= bn + 2'd1;
                txb <= mem[ptr];
                pull <= (rdm && bn == 2'd0) ? !mem[ptr][7] : 1'b0;
            end else if (rdm && bn != 2'd0 && bc >= 4'd1 && bc <= 4'd7) begin
                pull <= !txb[3'(7 - bc)];
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] cfgw(input bit en, input bit wide, input logic [6:0] sid,
                                         input logic [8:0] div, input bit mask, input bit compat);
        return (32'(en)) | (32'(wide) << 1) | (32'(sid) << 3) | (32'(div) << 10)
             | (32'(mask) << 22) | (32'(compat) << 23);
    endfunction

    function automatic logic [31:0] cmdw(input bit r, input logic [7:0] a, input logic [7:0] d);
        return (32'(r) << 24) | (32'(a) << 16) | 32'(d);
    endfunction

    task automatic wait_done(output bit ok);
        logic [31:0] v;
        ok = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            rd(2'd2, v);
            if (v[0]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic launch(input bit r, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        rises = 0;
        wr(2'd1, cmdw(r, a, d));
    endtask

    // ---------------- scenarios ----------------
    initial begin
        logic [31:0] v;
        bit ok;
        int s0, p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk(v == (32'h1FF << 10), "R1 cfg reset", v, 32'h1FF << 10);
        rd(2'd1, v); chk(v == 0, "R1 cmd reset", v, 0);
        rd(2'd2, v); chk(v == 0, "R1 status reset", v, 0);
        chk(scl_o && sda_line, "R1 bus released", {30'd0, scl_o, sda_line}, 32'd3);

        wr(2'd3, 32'd1);

        // sweep dividers: write then read back, plus untouched address
        for (int dv = 0; dv < 4; dv++) begin
            logic [7:0] a, d;
            a = 8'(dv * 16 + 5);
            d = 8'(8'hC0 + dv);
            wr(2'd0, cfgw(1, 0, SADDR, 9'(dv), 0, 0));
            s0 = starts; p0 = stops;
            launch(0, a, d);
            rd(2'd1, v); chk(v[25] == 1'b1, "R3 wpend set during write", v, 32'h0200_0000);
            wait_done(ok);
            chk(ok, "R3 write completes", 32'(ok), 1);
            chk(irq_o == 1'b1, "R10 irq pin with enable", 32'(irq_o), 1);
            rd(2'd1, v); chk(v[27:25] == 3'b000, "R3 wpend/err clear after write", v, 0);
            chk(mem[a] == d, "R3 sensor register written", 32'(mem[a]), 32'(d));
            exp_mem[a] = d;
            chk(t_r3 - t_r2 == 2 * (dv + 1), "R2 SCL period", 32'(t_r3 - t_r2), 32'(2 * (dv + 1)));
            chk(starts - s0 == 1 && stops - p0 == 1, "R11 write start/stop count",
                32'(starts - s0), 1);
            wr(2'd2, 32'd1);
            rd(2'd2, v); chk(v[0] == 1'b0 && irq_o == 1'b0, "R10 status W1C", v, 0);

            s0 = starts;
            launch(1, a, 8'h00);
            rd(2'd1, v); chk(v[26:25] == 2'b00, "R9 read cmd leaves wpend clear", v, 0);
            wait_done(ok);
            rd(2'd1, v);
            chk(v[27:26] == 2'b01 && v[15:0] == {8'h00, exp_mem[a]}, "R4 read data valid",
                v, {4'b0000, 4'b0100, a, 8'h00, exp_mem[a]} | 32'h0100_0000);
            chk(starts - s0 == 2, "R4 repeated start count", 32'(starts - s0), 2);
            wr(2'd2, 32'd1);

            // R9: new write clears read-valid
            launch(0, 8'hE0, 8'h5A);
            rd(2'd1, v); chk(v[26] == 1'b0 && v[25] == 1'b1, "R9 new cmd clears rval sets wpend", v, 32'h0200_0000);
            wait_done(ok);
            exp_mem[8'hE0] = 8'h5A;
            wr(2'd2, 32'd1);
        end

        // untouched address
        wr(2'd0, cfgw(1, 0, SADDR, 9'd1, 0, 0));
        launch(1, 8'hF3, 8'h00); wait_done(ok); wr(2'd2, 32'd1);
        rd(2'd1, v); chk(v[7:0] == init_val(8'hF3), "R4 untouched register", v, 32'(init_val(8'hF3)));

        // R5 NACK
        wr(2'd0, cfgw(1, 0, 7'h22, 9'd1, 0, 0));
        p0 = stops;
        launch(0, 8'h10, 8'h99); wait_done(ok); wr(2'd2, 32'd1);
        rd(2'd1, v); chk(v[27] == 1'b1 && v[25] == 1'b0, "R5 write NACK error", v, 32'h0800_0000);
        chk(stops - p0 == 1, "R5 stop after NACK", 32'(stops - p0), 1);
        chk(mem[8'h10] == exp_mem[8'h10], "R5 no sensor write", 32'(mem[8'h10]), 32'(exp_mem[8'h10]));
        launch(1, 8'h10, 8'h00); wait_done(ok); wr(2'd2, 32'd1);
        rd(2'd1, v); chk(v[27:26] == 2'b10, "R5 read NACK no rval", v, 32'h0800_0000);

        // R6 masked ack
        wr(2'd0, cfgw(1, 0, 7'h22, 9'd1, 1, 0));
        launch(0, 8'h11, 8'h77); wait_done(ok); wr(2'd2, 32'd1);
        rd(2'd1, v); chk(v[27:25] == 3'b000, "R6 masked NACK no error", v, 0);

        // R7 busy command ignored
        wr(2'd0, cfgw(1, 0, SADDR, 9'd2, 0, 0));
        launch(0, 8'h40, 8'h11);
        wr(2'd1, cmdw(0, 8'h41, 8'h22));
        wait_done(ok); wr(2'd2, 32'd1);
        exp_mem[8'h40] = 8'h11;
        rd(2'd1, v); chk(v[23:16] == 8'h40 && v[7:0] == 8'h11, "R7 cmd word kept", v, cmdw(0, 8'h40, 8'h11));
        chk(mem[8'h41] == exp_mem[8'h41], "R7 second write not on bus", 32'(mem[8'h41]), 32'(exp_mem[8'h41]));
        chk(mem[8'h40] == 8'h11, "R7 first write done", 32'(mem[8'h40]), 32'h11);

        // R8 disabled
        wr(2'd0, cfgw(0, 0, SADDR, 9'd0, 0, 0));
        s0 = starts;
        wr(2'd1, cmdw(0, 8'h50, 8'h33));
        repeat (20) begin
            @(negedge clk);
            if (!scl_o) s0 = -1000;
        end
        chk(s0 == starts, "R8 bus idle when disabled", 32'(s0), 32'(starts));
        rd(2'd1, v); chk(v[25] == 1'b0, "R8 no pending write", v, 0);
        rd(2'd2, v); chk(v[0] == 1'b0, "R8 no completion", v, 0);

        // R10 enable gating
        wr(2'd0, cfgw(1, 0, SADDR, 9'd0, 0, 0));
        wr(2'd3, 32'd0);
        launch(0, 8'h60, 8'h44); wait_done(ok);
        chk(ok && irq_o == 1'b0, "R10 pin gated off", 32'(irq_o), 0);
        wr(2'd3, 32'd1);
        @(negedge clk); chk(irq_o == 1'b1, "R10 pin after enable", 32'(irq_o), 1);
        wr(2'd2, 32'd1);
        @(negedge clk); chk(irq_o == 1'b0, "R10 pin after clear", 32'(irq_o), 0);
        exp_mem[8'h60] = 8'h44;

        // R12 option bits
        wr(2'd0, cfgw(1, 1, SADDR, 9'd1, 0, 1));
        rd(2'd0, v); chk(v == cfgw(1, 1, SADDR, 9'd1, 0, 1), "R12 option readback", v, cfgw(1, 1, SADDR, 9'd1, 0, 1));
        launch(0, 8'h70, 8'hA5); wait_done(ok); wr(2'd2, 32'd1);
        chk(mem[8'h70] == 8'hA5 && mem[8'h71] == exp_mem[8'h71], "R12 byte write in wide mode",
            32'(mem[8'h70]), 32'hA5);
        launch(1, 8'h70, 8'h00); wait_done(ok); wr(2'd2, 32'd1);
        rd(2'd1, v); chk(v[15:0] == 16'h00A5, "R12 byte read in wide mode", v, 32'h00A5);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule